// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave holds stuck after a transfer was cut short. When a start request arrives, it looks at the bus-busy flag and the sampled SDA level. If neither shows a problem, it reports completion one cycle later and leaves the pins alone. If either shows a problem, it takes the SCL pin away from the protocol controller through a pin-function override and pulls SCL low for one delay period. It then clocks the bus with a bounded number of SCL pulses, and stops early as soon as SDA reads high.

After the last pulse, SCL is held high for one more delay period. The override is then released, so the pins return to their normal function in the same cycle that a one-cycle done pulse appears. A status flag, updated with done, tells whether SDA was high when the sequence ended. The delay period is a parameter counted in clock cycles. Its default is 50000, which is 1 ms at a 50 MHz clock. The pulse limit is also a parameter, with a default of 10.

Top module: `bus_unjam_seq`

## Requirements
- R1: While reset is asserted and right after it: `pin_override`=0, `scl_drive`=1, `done`=0 and `sda_freed`=0.
- R2: If a start request sees `bus_busy`=0 and `sda_in`=1, `done` is 1 in the first cycle after the request edge. `pin_override` stays 0, `scl_drive` stays 1, and `sda_freed` becomes 1.
- R3: If a start request sees `bus_busy`=1 or `sda_in`=0, then from the first cycle after the request edge `pin_override` is 1 and `scl_drive` is 0, for exactly DELAY_CYCLES cycles.
- R4: Each recovery pulse drives `scl_drive` high for DELAY_CYCLES cycles and then low for DELAY_CYCLES cycles, with `pin_override` held at 1.
- R5: SDA is sampled at the end of every low period (the first low period and the low half of each pulse). If it reads 1, no further pulse is issued.
- R6: At most MAX_PULSES pulses are issued per sequence, even if SDA never goes high.
- R7: After the pulses, `scl_drive` is 1 for DELAY_CYCLES cycles with `pin_override`=1. Then `pin_override` falls in the same cycle that `done` rises.
- R8: `done` is high for exactly one cycle. For a sequence with p pulses it appears DELAY_CYCLES*(2p+2)+1 cycles after the request edge.
- R9: `sda_freed` changes only when `done` is 1. It then holds the SDA level sampled at the end of the final high period, which is 0 if SDA stayed low through MAX_PULSES pulses.
- R10: A start request that arrives while a sequence runs, including the cycle in which `done` is 1, is ignored. It does not extend or restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick | input | 1 | Start request, sampled only while idle |
| sda_in | input | 1 | Synchronised SDA pin level |
| bus_busy | input | 1 | Bus-busy flag from the I2C controller |
| scl_drive | output | 1 | SCL level to drive while the override is active (1 otherwise) |
| pin_override | output | 1 | 1 = pins under direct control of this block |
| done | output | 1 | One-cycle completion pulse |
| sda_freed | output | 1 | SDA level at the end of the last sequence |

## Verification
The bench models a slave that holds SDA low until a chosen number of SCL falling edges have passed. This sets the number of pulses the block should need, from none up to one more than the limit. A design that checked SDA one phase late would issue an extra pulse. One that miscounted the cap would stop at nine or eleven. One that sampled SDA before the tail would report a stale freed flag. The bench measures every SCL high and low run length while the override is active, and the total latency to done, so an off-by-one in the delay counter shows up directly. Start requests are also injected in the middle of a sequence and held across the done cycle. A design that accepted them would lengthen the sequence or emit a second done.

// File: rtl/bus_unjam_pkg.sv
package bus_unjam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LEAD_LOW = 3'd1,
    ST_PULSE_HI = 3'd2,
    ST_PULSE_LO = 3'd3,
    ST_TAIL_HI  = 3'd4,
    ST_FINISH   = 3'd5
  } unjam_state_e;

  // Recovery is required when the bus looks busy or SDA is held low.
  function automatic logic needs_recovery(input logic busy, input logic sda);
    return busy | ~sda;
  endfunction

  // Cycles spent with the override active for a run of 'pulses' pulses.
  function automatic int unsigned sequence_cycles(input int unsigned dly,
                                                  input int unsigned pulses);
    return dly * (2 * pulses + 2);
  endfunction

  // Width of a counter that must hold values 0..max_val.
  function automatic int unsigned count_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/unjam_delay_timer.sv
module unjam_delay_timer #(
  parameter int unsigned DELAY_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  import bus_unjam_pkg::*;

  localparam int unsigned CW = count_width(DELAY_CYCLES - 1);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] remain_q;

  // Loaded on entry to a timed phase; the phase lasts until it reads zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (load)            remain_q <= RELOAD;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign expire = (remain_q == '0);

endmodule

// File: rtl/unjam_pulse_tally.sv
module unjam_pulse_tally #(
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic final_pulse
);
  import bus_unjam_pkg::*;

  localparam int unsigned PW = count_width(MAX_PULSES);
  localparam logic [PW-1:0] LAST_IDX = PW'(MAX_PULSES - 1);

  logic [PW-1:0] issued_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     issued_q <= '0;
    else if (clear) issued_q <= '0;
    else if (bump)  issued_q <= issued_q + 1'b1;
  end

  // True while the pulse now running is the last one allowed.
  assign final_pulse = (issued_q == LAST_IDX);

endmodule

// File: rtl/unjam_ctrl.sv
module unjam_ctrl (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        kick,
  input  logic                        sda_in,
  input  logic                        bus_busy,
  input  logic                        phase_over,
  input  logic                        final_pulse,
  output logic                        timer_load,
  output logic                        tally_clear,
  output logic                        tally_bump,
  output logic                        freed_q,
  output bus_unjam_pkg::unjam_state_e state_q
);
  import bus_unjam_pkg::*;

  unjam_state_e state_d;
  logic         freed_d;

  always_comb begin
    state_d     = state_q;
    freed_d     = freed_q;
    timer_load  = 1'b0;
    tally_clear = 1'b0;
    tally_bump  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (kick) begin
          if (needs_recovery(bus_busy, sda_in)) begin
            state_d     = ST_LEAD_LOW;
            timer_load  = 1'b1;
            tally_clear = 1'b1;
          end else begin
            state_d = ST_FINISH;
            freed_d = sda_in;
          end
        end
      end
      ST_LEAD_LOW: begin
        if (phase_over) begin
          timer_load = 1'b1;
          state_d    = sda_in ? ST_TAIL_HI : ST_PULSE_HI;
        end
      end
      ST_PULSE_HI: begin
        if (phase_over) begin
          timer_load = 1'b1;
          state_d    = ST_PULSE_LO;
        end
      end
      ST_PULSE_LO: begin
        if (phase_over) begin
          timer_load = 1'b1;
          tally_bump = 1'b1;
          state_d    = (sda_in || final_pulse) ? ST_TAIL_HI : ST_PULSE_HI;
        end
      end
      ST_TAIL_HI: begin
        if (phase_over) begin
          freed_d = sda_in;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      freed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      freed_q <= freed_d;
    end
  end

endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq #(
  parameter int unsigned DELAY_CYCLES = 50000,
  parameter int unsigned MAX_PULSES   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic sda_in,
  input  logic bus_busy,
  output logic scl_drive,
  output logic pin_override,
  output logic done,
  output logic sda_freed
);
  import bus_unjam_pkg::*;

  unjam_state_e state;
  logic         phase_over;
  logic         final_pulse;
  logic         timer_load;
  logic         tally_clear;
  logic         tally_bump;

  unjam_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick        (kick),
    .sda_in      (sda_in),
    .bus_busy    (bus_busy),
    .phase_over  (phase_over),
    .final_pulse (final_pulse),
    .timer_load  (timer_load),
    .tally_clear (tally_clear),
    .tally_bump  (tally_bump),
    .freed_q     (sda_freed),
    .state_q     (state)
  );

  unjam_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (timer_load),
    .expire (phase_over)
  );

  unjam_pulse_tally #(.MAX_PULSES(MAX_PULSES)) u_tally (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (tally_clear),
    .bump        (tally_bump),
    .final_pulse (final_pulse)
  );

  // Pin-side outputs decode straight from the registered state.
  assign pin_override = (state == ST_LEAD_LOW) || (state == ST_PULSE_HI) ||
                        (state == ST_PULSE_LO) || (state == ST_TAIL_HI);
  assign scl_drive    = !((state == ST_LEAD_LOW) || (state == ST_PULSE_LO));
  assign done         = (state == ST_FINISH);

endmodule

// File: rtl/bus_unjam_chk.sv
module bus_unjam_chk #(
  parameter int unsigned DELAY_CYCLES = 50000,
  parameter int unsigned MAX_PULSES   = 10
) (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic scl_drive,
  input logic pin_override,
  input logic done,
  input logic sda_freed
);
  import bus_unjam_pkg::*;

  localparam int unsigned RW = count_width(MAX_PULSES + 2);
  localparam logic [31:0] LEN_CAP = 32'(sequence_cycles(DELAY_CYCLES, MAX_PULSES));

  logic          scl_prev;
  logic [RW-1:0] rise_cnt;
  logic [31:0]   ovr_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      rise_cnt <= '0;
      ovr_len  <= '0;
    end else begin
      scl_prev <= scl_drive;
      if (!pin_override) begin
        rise_cnt <= '0;
        ovr_len  <= '0;
      end else begin
        ovr_len <= ovr_len + 1;
        if (scl_drive && !scl_prev) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  a_r1_scl_high_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_override |-> scl_drive);

  a_r3_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_override) |-> !scl_drive);

  a_r6_rise_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= RW'(MAX_PULSES + 1));

  a_r7_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_override) |-> done);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_length_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_len <= LEN_CAP);

  a_r9_freed_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_freed) |-> done);

  a_r10_kick_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_override && kick) |=> (pin_override || done));

endmodule

bind bus_unjam_seq bus_unjam_chk #(
  .DELAY_CYCLES (DELAY_CYCLES),
  .MAX_PULSES   (MAX_PULSES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .kick         (kick),
  .scl_drive    (scl_drive),
  .pin_override (pin_override),
  .done         (done),
  .sda_freed    (sda_freed)
);

// File: tb/test_bus_unjam_seq.sv
`timescale 1ns/1ps
module test_bus_unjam_seq;
  localparam int unsigned DLY = 6;
  localparam int unsigned MAXP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic bus_busy = 1'b0;
  logic stuck = 1'b0;
  int unsigned hold_falls = 0;
  int unsigned falls = 0;
  logic sda_in;
  logic scl_drive, pin_override, done, sda_freed;

  int n_checks = 0;
  int n_fails = 0;

  // Slave model: holds SDA low until more than hold_falls SCL falls occur.
  assign sda_in = !(stuck && (falls <= hold_falls));

  always #10 clk = ~clk;

  bus_unjam_seq #(.DELAY_CYCLES(DLY), .MAX_PULSES(MAXP)) i_bus_unjam_seq (
    .clk(clk), .rst_n(rst_n), .kick(kick), .sda_in(sda_in), .bus_busy(bus_busy),
    .scl_drive(scl_drive), .pin_override(pin_override), .done(done),
    .sda_freed(sda_freed)
  );

  function automatic int unsigned exp_pulses(input bit need, input bit stk,
                                             input int unsigned hf);
    if (!need || !stk) return 0;
    return (hf < MAXP) ? hf : MAXP;
  endfunction

  function automatic int unsigned exp_latency(input bit need, input int unsigned p);
    return need ? DLY * (2 * p + 2) + 1 : 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 plain, 1 extra request mid-run, 2 request held across done
  task automatic episode(input bit busy, input bit stk, input int unsigned hf,
                         input int mode);
    bit need;
    int unsigned p, exp_cyc, cyc, rises, hi_len, lo_len, bad_w;
    bit exp_free, prev;
    @(negedge clk);
    bus_busy = busy; stuck = stk; hold_falls = hf; falls = 0; kick = 1'b1;
    need = busy || stk;
    p = exp_pulses(need, stk, hf);
    exp_free = need ? (!stk || hf <= MAXP) : 1'b1;
    exp_cyc = exp_latency(need, p);
    cyc = 0; rises = 0; hi_len = 0; lo_len = 0; bad_w = 0; prev = 1'b1;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        if (mode != 2) kick = 1'b0;
        if (need) begin
          check(pin_override == 1'b1, "R3 override on", pin_override, 1);
          check(scl_drive == 1'b0, "R3 lead low", scl_drive, 0);
        end else begin
          check(pin_override == 1'b0, "R2 no override", pin_override, 0);
          check(scl_drive == 1'b1, "R2 scl high", scl_drive, 1);
        end
      end
      if (mode == 1 && cyc == 3) kick = 1'b1;
      if (mode == 1 && cyc == 4) kick = 1'b0;
      if (pin_override) begin
        if (scl_drive) begin
          if (!prev) begin
            if (lo_len != DLY) bad_w++;
            rises++; hi_len = 0;
          end
          hi_len++;
        end else begin
          if (prev) begin
            if (rises > 0 && hi_len != DLY) bad_w++;
            falls++; lo_len = 0;
          end
          lo_len++;
        end
      end
      prev = scl_drive;
      if (done || cyc > DLY * (2 * MAXP + 6) + 10) break;
    end
    check(done == 1'b1 && cyc == exp_cyc, "R8 latency", cyc, exp_cyc);
    check(pin_override == 1'b0, "R7 release at done", pin_override, 0);
    check(sda_freed == exp_free, "R9 freed flag", sda_freed, exp_free);
    if (need) begin
      check(rises == p + 1, "R5 R6 pulse count", rises, p + 1);
      check(bad_w == 0, "R4 phase widths", bad_w, 0);
      check(hi_len == DLY, "R7 tail high", hi_len, DLY);
    end else begin
      check(rises == 0, "R2 no pulses", rises, 0);
    end
    @(negedge clk);
    kick = 1'b0;
    check(done == 1'b0, "R8 done single", done, 0);
    check(pin_override == 1'b0, "R10 no restart", pin_override, 0);
    @(negedge clk);
    check(done == 1'b0 && pin_override == 1'b0, "R10 idle after", done, 0);
    check(sda_freed == exp_free, "R9 freed held", sda_freed, exp_free);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h51ab));
    repeat (3) @(negedge clk);
    check(pin_override == 1'b0 && scl_drive == 1'b1, "R1 reset pins", pin_override, 0);
    check(done == 1'b0 && sda_freed == 1'b0, "R1 reset flags", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pin_override == 1'b0 && done == 1'b0, "R1 after reset", done, 0);
    episode(1'b0, 1'b0, 0, 0);    // R2 nothing to do
    episode(1'b0, 1'b0, 0, 2);    // R10 request held over done
    episode(1'b1, 1'b0, 0, 0);    // busy only, SDA high: tail only
    episode(1'b0, 1'b1, 0, 0);    // R5 released by the lead low
    episode(1'b0, 1'b1, 3, 1);    // R10 extra request mid-run
    episode(1'b0, 1'b1, 9, 0);
    episode(1'b0, 1'b1, MAXP, 0); // R6 freed on the last pulse
    episode(1'b1, 1'b1, MAXP + 1, 0); // R6 R9 never freed
    episode(1'b0, 1'b1, MAXP + 1, 2);
    for (int k = 0; k < 24; k++)
      episode(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              $urandom_range(0, MAXP + 3), int'($urandom_range(0, 2)));
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule